// File: doc/BRIEF.md
# 8-bit interval timer and PWM generator

This block is an up-counter with two modes. In interval mode it counts selected clock ticks up to a compare value. It then restarts from zero, toggles its output pin and raises an interrupt flag. The result is a square wave with a programmable period, plus a periodic event. In PWM mode the counter runs freely through all of its states. The pin is high while the count is below the compare value, which gives a duty of compare/256.

Software drives the block through a control register and a compare register, both written over a simple write strobe with a data bus.

The compare register is double-buffered. Its value moves into a comparator latch only while the counter sits at zero, so a new value never cuts a running period short. The count clock is one of several clock-enable pulses from an external prescaler, picked by a select field.

The interrupt flag is set by every interval match, even when the interrupt is disabled. Software clears it by writing zero to it. During a read-modify-write access the flag reads as one, so writing the read value back cannot clear it.

Top module: `tmr8_pwm_unit`

## Requirements
- R1: After reset every control field, the compare register, the latch and the counter are zero, and `ctrl_rdata` reads 0. While the run bit (control bit 1) is 0, the counter is held at 0 and `out_pin` is low. Once run is set, the counter starts from 0 and increments once per selected tick.
- R2: The clock-select field (control bits 5:4 by default) picks `tick_in[sel]` as the count tick. Pulses on the other tick inputs do not move the counter.
- R3: In interval mode (control bit 0 = 0), a tick that arrives while the counter equals the latch returns the counter to 0. A latch value L therefore gives a period of L+1 ticks: 00h gives one tick and FFh gives 256 ticks.
- R4: Each interval-mode match toggles `out_pin` and sets the interrupt flag (control bit 3).
- R5: The latch takes the compare register's value on every clock in which the counter is 0. A compare write in the middle of a period leaves that period's length unchanged and takes effect from the next period.
- R6: The flag is set by a match whatever the enable bit (control bit 2) holds. `irq` is high only when both the flag and the enable bit are 1.
- R7: A control write with bit 3 = 0 clears the flag, and a write with bit 3 = 1 leaves it unchanged. If a match and a clearing write fall in the same clock, the flag ends up set.
- R8: While `rd_rmw` is high, bit 3 of `ctrl_rdata` reads 1 whatever the flag holds.
- R9: In PWM mode (control bit 0 = 1) the counter wraps from FFh to 00h, and `out_pin` is high exactly while the counter is below the latch. The duty is therefore latch/256: 00h gives always low, 80h gives half of the clocks high and FFh gives 255 of 256 high.
- R10: A control write that changes the mode bit returns the counter to 0 and clears the interval toggle state, so `out_pin` goes low in interval mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 2**SEL_W (4) | Clock-enable pulses from the prescaler |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_cmp | input | 1 | Write strobe for the compare register |
| wdata | input | CNT_W (8) | Write data |
| rd_rmw | input | 1 | High during the read half of a read-modify-write access |
| ctrl_rdata | output | CNT_W (8) | Control register read value |
| out_pin | output | 1 | Timer or PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- Tick pulses and write strobes are one-clock synchronous enables.
- `rd_rmw` is only a read qualifier and changes no state.
- Reset is held for at least one clock edge.

The bench keeps within these by driving every input on the falling edge. The ticks come from a regular divide-by-1/2/4/8 pattern. Each register write lasts exactly one clock. Clears, mode switches and compare rewrites are placed both in the middle of a period and next to match cycles, so the set-versus-clear and latch-timing corners occur.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   // control register field positions (select field starts at CB_SEL)
   localparam int CB_MODE = 0;
   localparam int CB_RUN  = 1;
   localparam int CB_IEN  = 2;
   localparam int CB_FLAG = 3;
   localparam int CB_SEL  = 4;
   localparam int CB_FIXED = 4;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_PWM      = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/tmr8_tick_sel.sv
module tmr8_tick_sel #(
   parameter int SEL_W = 2,
   localparam int N_TICK = 1 << SEL_W
) (
   input  logic [N_TICK-1:0] tick_in,
   input  logic [SEL_W-1:0]  sel,
   output logic              tick
);
   logic [N_TICK-1:0] hit;

   generate
      for (genvar gi = 0; gi < N_TICK; gi++) begin : g_hit
         assign hit[gi] = tick_in[gi] && (sel == SEL_W'(gi));
      end
   endgenerate

   assign tick = |hit;
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             mode_pwm,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] latch,
   output logic             match
);
   logic at_zero;

   assign at_zero = (cnt == '0);
   assign match   = !mode_pwm && run && tick && (cnt == latch);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         latch <= '0;
      end else begin
         if (at_zero) begin
            latch <= cmp_val;
         end
         if (!run || restart) begin
            cnt <= '0;
         end else if (tick) begin
            if (match) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             mode_pwm,
   input  logic             restart,
   input  logic             match,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] latch,
   output logic             out_pin
);
   logic tog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog <= 1'b0;
      end else if (!run || restart) begin
         tog <= 1'b0;
      end else if (match) begin
         tog <= !tog;
      end
   end

   assign out_pin = run && (mode_pwm ? (cnt < latch) : tog);
endmodule

// File: rtl/tmr8_pwm_unit.sv
module tmr8_pwm_unit #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 2,
   localparam int N_TICK = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TICK-1:0] tick_in,
   input  logic              wr_ctrl,
   input  logic              wr_cmp,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              rd_rmw,
   output logic [CNT_W-1:0]  ctrl_rdata,
   output logic              out_pin,
   output logic              irq
);
   import tmr8_pkg::*;

   localparam int CTRL_USED = CB_FIXED + SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("SEL_W must be 1 to 3");
      end
      if (CNT_W < CTRL_USED) begin : g_bad_width
         $error("CNT_W too narrow for the control fields");
      end
   endgenerate

   tmr_mode_e        mode_q;
   logic             run_q;
   logic             ien_q;
   logic             flag_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cmp_q;
   logic             tick;
   logic             restart;
   logic             match;
   logic             mode_pwm;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] latch;

   assign mode_pwm = (mode_q == MODE_PWM);
   assign restart  = wr_ctrl && (wdata[CB_MODE] != mode_pwm);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_INTERVAL;
         run_q  <= 1'b0;
         ien_q  <= 1'b0;
         sel_q  <= '0;
         cmp_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            mode_q <= tmr_mode_e'(wdata[CB_MODE]);
            run_q  <= wdata[CB_RUN];
            ien_q  <= wdata[CB_IEN];
            sel_q  <= wdata[CB_SEL +: SEL_W];
         end
         if (wr_cmp) begin
            cmp_q <= wdata;
         end
      end
   end

   // flag: set has priority over a software clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match) begin
         flag_q <= 1'b1;
      end else if (wr_ctrl && !wdata[CB_FLAG]) begin
         flag_q <= 1'b0;
      end
   end

   tmr8_tick_sel #(.SEL_W(SEL_W)) u_sel (
      .tick_in (tick_in),
      .sel     (sel_q),
      .tick    (tick)
   );

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .mode_pwm (mode_pwm),
      .restart  (restart),
      .tick     (tick),
      .cmp_val  (cmp_q),
      .cnt      (cnt),
      .latch    (latch),
      .match    (match)
   );

   tmr8_wave #(.CNT_W(CNT_W)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .mode_pwm (mode_pwm),
      .restart  (restart),
      .match    (match),
      .cnt      (cnt),
      .latch    (latch),
      .out_pin  (out_pin)
   );

   always_comb begin
      ctrl_rdata                   = '0;
      ctrl_rdata[CB_MODE]          = mode_pwm;
      ctrl_rdata[CB_RUN]           = run_q;
      ctrl_rdata[CB_IEN]           = ien_q;
      ctrl_rdata[CB_FLAG]          = flag_q || rd_rmw;
      ctrl_rdata[CB_SEL +: SEL_W]  = sel_q;
   end

   assign irq = flag_q && ien_q;
endmodule

// File: rtl/tmr8_pwm_unit_chk.sv
module tmr8_pwm_unit_chk #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             mode_pwm,
   input logic             ien,
   input logic             flag,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] latch,
   input logic             tick,
   input logic             wr_ctrl,
   input logic [CNT_W-1:0] wdata,
   input logic             rd_rmw,
   input logic [CNT_W-1:0] ctrl_rdata,
   input logic             out_pin,
   input logic             irq
);
   logic ivl_hit;
   assign ivl_hit = !mode_pwm && run && tick && (cnt == latch);

   AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !out_pin);  // R1
   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));  // R1
   AST_IVL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ivl_hit |=> (cnt == '0));  // R3
   AST_IVL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ivl_hit |=> flag);  // R4
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(latch));  // R5
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && flag));  // R6
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[3] && !ivl_hit) |=> !flag);  // R7
   AST_RMW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rmw |-> ctrl_rdata[3]);  // R8
   AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_pwm && (latch == '0)) |-> !out_pin);  // R9
   AST_PWM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_pwm && tick && !wr_ctrl) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));  // R9
   AST_SWITCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && (wdata[0] != mode_pwm)) |=> (cnt == '0));  // R10
endmodule

bind tmr8_pwm_unit tmr8_pwm_unit_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run_q),
   .mode_pwm   (mode_pwm),
   .ien        (ien_q),
   .flag       (flag_q),
   .cnt        (cnt),
   .latch      (latch),
   .tick       (tick),
   .wr_ctrl    (wr_ctrl),
   .wdata      (wdata),
   .rd_rmw     (rd_rmw),
   .ctrl_rdata (ctrl_rdata),
   .out_pin    (out_pin),
   .irq        (irq)
);

// File: tb/tmr8_pwm_unit_test.sv
`timescale 1ns/1ps
module tmr8_pwm_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] tick_in = '0;
   logic       wr_ctrl = 1'b0;
   logic       wr_cmp = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd_rmw = 1'b0;
   logic [7:0] ctrl_rdata;
   logic       out_pin;
   logic       irq;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   int    pre = 0;

   always #10 clk = !clk;

   tmr8_pwm_unit uut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_ctrl(wr_ctrl),
      .wr_cmp(wr_cmp), .wdata(wdata), .rd_rmw(rd_rmw),
      .ctrl_rdata(ctrl_rdata), .out_pin(out_pin), .irq(irq)
   );

   // prescaler pattern: divide by 1, 2, 4, 8
   always @(negedge clk) begin
      pre = pre + 1;
      tick_in[0] <= 1'b1;
      tick_in[1] <= (pre % 2) == 0;
      tick_in[2] <= (pre % 4) == 0;
      tick_in[3] <= (pre % 8) == 0;
   end

   // behavioural reference model
   int m_cnt, m_lat, m_cmp, m_mode, m_run, m_ien, m_flag, m_sel, m_tog;
   always @(posedge clk) begin
      int  tk;
      bit  hit, sw;
      if (!rst_n) begin
         m_cnt = 0; m_lat = 0; m_cmp = 0; m_mode = 0; m_run = 0;
         m_ien = 0; m_flag = 0; m_sel = 0; m_tog = 0;
      end else begin
         tk  = tick_in[m_sel];
         hit = (m_mode == 0) && m_run == 1 && tk == 1 && (m_cnt == m_lat);
         sw  = wr_ctrl && (int'(wdata[0]) != m_mode);
         if (m_cnt == 0) m_lat = m_cmp;
         if (m_run == 0 || sw) begin
            m_cnt = 0; m_tog = 0;
         end else if (tk == 1) begin
            if (hit) begin m_cnt = 0; m_tog = 1 - m_tog; end
            else m_cnt = (m_cnt + 1) % 256;
         end
         if (hit) m_flag = 1;
         else if (wr_ctrl && !wdata[3]) m_flag = 0;
         if (wr_ctrl) begin
            m_mode = wdata[0]; m_run = wdata[1]; m_ien = wdata[2]; m_sel = wdata[5:4];
         end
         if (wr_cmp) m_cmp = wdata;
      end
   end

   function automatic int exp_out();
      if (m_run == 0) return 0;
      if (m_mode == 1) return (m_cnt < m_lat) ? 1 : 0;
      return m_tog;
   endfunction

   function automatic int exp_rd();
      return (m_sel << 4) | (((m_flag == 1) || rd_rmw) ? 8 : 0) | (m_ien << 2) | (m_run << 1) | m_mode;
   endfunction

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #5;
      if (rst_n && !done) begin
         chk(cur_req, int'(out_pin), exp_out(), "out_pin vs model");
         chk(cur_req, int'(irq), m_flag & m_ien, "irq vs model");
         chk(cur_req, int'(ctrl_rdata), exp_rd(), "ctrl_rdata vs model");
      end
   end

   task automatic wctrl(input int mode, input int run, input int ien, input int fl, input int sel);
      @(negedge clk);
      wr_ctrl = 1'b1;
      wdata = 8'((sel << 4) | (fl << 3) | (ien << 2) | (run << 1) | mode);
      @(negedge clk);
      wr_ctrl = 1'b0;
   endtask

   task automatic wcmp(input int v);
      @(negedge clk);
      wr_cmp = 1'b1;
      wdata = 8'(v);
      @(negedge clk);
      wr_cmp = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // clocks between two successive output changes
   task automatic gap(output int g);
      logic p;
      @(negedge clk); #5;
      p = out_pin;
      while (out_pin == p) begin @(negedge clk); #5; end
      p = out_pin; g = 0;
      while (out_pin == p) begin @(negedge clk); #5; g++; end
   endtask

   task automatic duty(output int h);
      h = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk); #5;
         if (out_pin) h++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int g, h;
      idle(3);
      #5;
      chk("R1", int'(ctrl_rdata), 0, "reset ctrl_rdata");
      chk("R1", int'(out_pin), 0, "reset out_pin");
      chk("R1", int'(irq), 0, "reset irq");
      @(negedge clk);
      rst_n = 1'b1;
      idle(4);

      cur_req = "R3";
      wcmp(0);
      wctrl(0, 1, 0, 1, 0);
      gap(g); chk("R3", g, 1, "period latch 00h sel0");
      wcmp(3);
      wctrl(0, 1, 0, 1, 1);
      idle(20);
      gap(g); chk("R3", g, 8, "period latch 3 sel1");

      cur_req = "R2";
      wctrl(0, 1, 0, 1, 2);
      idle(40);
      gap(g); chk("R2", g, 16, "period sel2");
      wctrl(0, 1, 0, 1, 3);
      idle(80);
      gap(g); chk("R2", g, 32, "period sel3");

      cur_req = "R4";
      #5;
      chk("R4", int'(ctrl_rdata[3]), 1, "flag set by match");
      cur_req = "R6";
      chk("R6", int'(irq), 0, "irq low with enable off");
      wctrl(0, 1, 1, 1, 3);
      #5;
      chk("R6", int'(irq), 1, "irq high with enable on");

      cur_req = "R7";
      wctrl(0, 0, 1, 1, 0);
      idle(2); #5;
      chk("R7", int'(ctrl_rdata[3]), 1, "write 1 keeps flag");
      wctrl(0, 0, 1, 0, 0);
      #5;
      chk("R7", int'(ctrl_rdata[3]), 0, "write 0 clears flag");
      wctrl(0, 0, 1, 1, 0);
      #5;
      chk("R7", int'(ctrl_rdata[3]), 0, "write 1 does not set flag");
      cur_req = "R8";
      @(negedge clk); rd_rmw = 1'b1; #5;
      chk("R8", int'(ctrl_rdata[3]), 1, "rmw read shows flag");
      @(negedge clk); rd_rmw = 1'b0; #5;
      chk("R8", int'(ctrl_rdata[3]), 0, "plain read shows flag");

      cur_req = "R7";
      wcmp(0);
      wctrl(0, 1, 0, 1, 0);
      idle(4);
      wctrl(0, 1, 0, 0, 0);
      #5;
      chk("R7", int'(ctrl_rdata[3]), 1, "set wins over clear");

      cur_req = "R5";
      wctrl(0, 0, 0, 0, 0);
      wcmp(255);
      wctrl(0, 1, 0, 0, 0);
      idle(50);
      wcmp(2);
      g = 0;
      @(negedge clk); #5;
      while (out_pin == 1'b0) begin @(negedge clk); #5; g++; end
      chk("R5", int'(g > 150), 1, "mid-period rewrite keeps 256-tick period");
      gap(h); chk("R5", h, 3, "new latch value next period");

      cur_req = "R9";
      wcmp(128);
      wctrl(1, 1, 0, 0, 0);
      idle(300);
      duty(h); chk("R9", h, 128, "duty 80h");
      wcmp(0);
      idle(300);
      duty(h); chk("R9", h, 0, "duty 00h");
      wcmp(255);
      idle(300);
      duty(h); chk("R9", h, 255, "duty FFh");

      cur_req = "R10";
      wcmp(200);
      idle(300);
      wctrl(0, 1, 0, 0, 0);
      #5;
      chk("R10", int'(out_pin), 0, "switch to interval clears output");
      idle(300);
      wctrl(1, 1, 0, 0, 0);
      idle(1); #5;
      chk("R10", int'(out_pin), 1, "switch to PWM restarts below latch");
      idle(20);
      wctrl(1, 0, 0, 0, 0);
      cur_req = "R1";
      idle(3); #5;
      chk("R1", int'(out_pin), 0, "stopped output low");
      idle(2);
      finish_run();
   end
endmodule